// File: doc/BRIEF.md
# Synthesizer Serial Loader

This block programs external frequency synthesizers over a three-wire style link: one serial data line, one serial clock and three latch-enable strobes, one per synthesizer. A host fills a 32-bit data word and three control bytes through a simple 8-bit write port. The write to the last control byte launches a programming cycle. The block then shifts out between 1 and 31 bits of the word. When the cycle ends it optionally strobes one or more latch lines. The host polls a ready output to learn when the link is free again.

All link timing is measured in ticks of a slow base enable (nominally 303.75 kHz) supplied on the `tick` input. The idle and active widths of the serial clock, its resting level, the number of bits and the shift direction are all taken from the control bytes. A cycle may leave every latch line quiet. Words longer than one cycle can carry are split across several cycles, and only the final one strobes the latch.

Top module: `synth_loader`

## Requirements
- R1: After reset `ready` is 1 and `ser_clk`, `ser_data` and `latch` are all 0.
- R2: Write addresses are as follows. Addresses 0 to 3 hold data bytes, least significant first. Address 4 holds the latch select in bits 7..5 and the idle width in bits 4..0. Address 5 holds the order flag in bit 5 and the active width in bits 4..0. Address 6 holds the clock resting level in bit 5 and the bit count in bits 4..0. A write to address 6 while ready starts a cycle.
- R3: `ready` is 0 in the cycle after a starting write. It stays 0 until the cycle completes, and it is 1 at the first tick after completion.
- R4: A bit count n of 1 to 31 shifts n clock pulses. A count of 0 shifts exactly one.
- R5: The bits sent are word bits 0..n-1. With the order flag 1 they go out from bit n-1 down to bit 0; with it 0 they go out from bit 0 upward.
- R6: Every idle clock phase lasts idle width + 1 ticks, and every active phase lasts active width + 1 ticks.
- R7: With resting level 0 the clock rests low and pulses high; with 1 it rests high and pulses low. `ser_data` changes only at the start of an idle phase and is stable through the active phase.
- R8: Latch select bit i drives `latch[i]`. If the select is nonzero, the last clock pulse is followed by an idle gap of idle width + 1 ticks and then by `latch` equal to the select for active width + 1 ticks, with the clock resting. If the select is 0, no latch line rises and the cycle ends with the last active phase.
- R9: Writes to any address while a cycle is in progress are ignored: the running waveform and the stored registers are unchanged.
- R10: Between ticks the serial outputs hold their values, except at the start of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle base timing enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ready | output | 1 | High when no programming cycle is pending or running |
| ser_clk | output | 1 | Serial clock to the synthesizers |
| ser_data | output | 1 | Serial data to the synthesizers |
| latch | output | 3 | Latch-enable strobes, one per synthesizer |

## Verification
The sweep covers both resting levels, both shift orders, six latch selects, bit counts of 0, 1, 3 and 31, and three pairs of idle and active widths. Each run is compared tick by tick against a waveform built arithmetically from the settings. A bit-order fault therefore shows up as wrong data, a width fault as a misplaced edge, and a select fault as a wrong or missing strobe. The count of 0 separates the forced single pulse from an empty cycle. The select of 0 separates an early ready from a late one. One run injects data, select and start writes mid-cycle. It is then restarted with only a start write, which shows that neither the live waveform nor the stored word and select moved.

// File: rtl/synld_pkg.sv
package synld_pkg;
    parameter int unsigned BYTES   = 4;
    parameter int unsigned FIELD_W = 5;
    parameter int unsigned LATCH_N = 3;
    localparam int unsigned DATA_W   = 8 * BYTES;
    localparam int unsigned NREGS    = BYTES + 3;
    localparam int unsigned ADDR_W   = $clog2(NREGS);
    localparam int unsigned IDX_W    = $clog2(DATA_W);
    localparam int unsigned A_CTRL0  = BYTES;
    localparam int unsigned A_CTRL1  = BYTES + 1;
    localparam int unsigned A_START  = BYTES + 2;
    localparam int unsigned FLAG_BIT = 5;

    typedef struct packed {
        logic [DATA_W-1:0]  word;
        logic [LATCH_N-1:0] sel;
        logic [FIELD_W-1:0] lo_w;
        logic [FIELD_W-1:0] hi_w;
        logic               msb_first;
        logic               idle_hi;
        logic [FIELD_W-1:0] nbits;
    } cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LO,
        PH_HI,
        PH_GAP,
        PH_LATCH
    } phase_t;
endpackage

// File: rtl/synld_regs.sv
module synld_regs
    import synld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              seq_busy,
    output cfg_t              cfg,
    output logic              go,
    output logic              ready
);
    typedef struct packed {
        cfg_t cfg;
        logic go;
    } regs_t;

    regs_t st_d, st_q;
    logic  locked;

    assign locked = seq_busy | st_q.go;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (wr_en && !locked) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_addr == ADDR_W'(b)) begin
                    st_d.cfg.word[8*b +: 8] = wr_data;
                end
            end
            if (wr_addr == ADDR_W'(A_CTRL0)) begin
                st_d.cfg.sel  = wr_data[7 -: LATCH_N];
                st_d.cfg.lo_w = wr_data[FIELD_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_CTRL1)) begin
                st_d.cfg.msb_first = wr_data[FLAG_BIT];
                st_d.cfg.hi_w      = wr_data[FIELD_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_START)) begin
                st_d.cfg.idle_hi = wr_data[FLAG_BIT];
                st_d.cfg.nbits   = wr_data[FIELD_W-1:0];
                st_d.go          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.cfg;
    assign go    = st_q.go;
    assign ready = !locked;
endmodule

// File: rtl/synld_seq.sv
module synld_seq
    import synld_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               go,
    input  cfg_t               cfg,
    output logic               busy,
    output logic               ser_clk,
    output logic               ser_data,
    output logic [LATCH_N-1:0] latch
);
    typedef struct packed {
        phase_t             phase;
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] k;
        logic               dat;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [FIELD_W-1:0] last_k;

    // a zero count still produces one clock pulse
    assign last_k = (cfg.nbits == '0) ? '0 : cfg.nbits - 1'b1;

    function automatic logic pick_bit(input cfg_t c, input logic [FIELD_W-1:0] lk,
                                      input logic [FIELD_W-1:0] pos);
        logic [FIELD_W-1:0] idx;
        idx = c.msb_first ? (lk - pos) : pos;
        return c.word[IDX_W'(idx)];
    endfunction

    always_comb begin
        sq_d = sq_q;
        if (sq_q.phase == PH_IDLE) begin
            if (go) begin
                sq_d.phase = PH_LO;
                sq_d.cnt   = cfg.lo_w;
                sq_d.k     = '0;
                sq_d.dat   = pick_bit(cfg, last_k, '0);
            end
        end else if (tick) begin
            if (sq_q.cnt != '0) begin
                sq_d.cnt = sq_q.cnt - 1'b1;
            end else begin
                unique case (sq_q.phase)
                    PH_LO: begin
                        sq_d.phase = PH_HI;
                        sq_d.cnt   = cfg.hi_w;
                    end
                    PH_HI: begin
                        if (sq_q.k == last_k) begin
                            if (|cfg.sel) begin
                                sq_d.phase = PH_GAP;
                                sq_d.cnt   = cfg.lo_w;
                            end else begin
                                sq_d.phase = PH_IDLE;
                            end
                        end else begin
                            sq_d.phase = PH_LO;
                            sq_d.cnt   = cfg.lo_w;
                            sq_d.k     = sq_q.k + 1'b1;
                            sq_d.dat   = pick_bit(cfg, last_k, sq_q.k + 1'b1);
                        end
                    end
                    PH_GAP: begin
                        sq_d.phase = PH_LATCH;
                        sq_d.cnt   = cfg.hi_w;
                    end
                    default: begin
                        sq_d.phase = PH_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy     = (sq_q.phase != PH_IDLE);
    assign ser_clk  = cfg.idle_hi ^ (sq_q.phase == PH_HI);
    assign ser_data = sq_q.dat;
    assign latch    = (sq_q.phase == PH_LATCH) ? cfg.sel : '0;
endmodule

// File: rtl/synth_loader.sv
module synth_loader
    import synld_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic               ready,
    output logic               ser_clk,
    output logic               ser_data,
    output logic [LATCH_N-1:0] latch
);
    cfg_t cfg;
    logic go;
    logic seq_busy;
    logic idle_lvl;
    logic [LATCH_N-1:0] sel_now;

    synld_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .seq_busy (seq_busy),
        .cfg      (cfg),
        .go       (go),
        .ready    (ready)
    );

    synld_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (go),
        .cfg      (cfg),
        .busy     (seq_busy),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .latch    (latch)
    );

    assign idle_lvl = cfg.idle_hi;
    assign sel_now  = cfg.sel;
endmodule

// File: rtl/synld_chk.sv
module synld_chk
    import synld_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               go,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               ready,
    input logic               ser_clk,
    input logic               ser_data,
    input logic [LATCH_N-1:0] latch,
    input logic               idle_lvl,
    input logic [LATCH_N-1:0] sel_now
);
    assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_START) && ready) |=> !ready);

    assert_clk_rests_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ser_clk == idle_lvl));

    assert_data_held_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && ser_clk != idle_lvl && $past(ser_clk != idle_lvl)) |-> $stable(ser_data));

    assert_latch_in_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch & ~sel_now) == '0);

    assert_latch_clk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|latch) |-> (ser_clk == idle_lvl));

    assert_tick_paces_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(go) && !$past(wr_en))
            |-> ($stable(ser_clk) && $stable(ser_data) && $stable(latch)));
endmodule

bind synth_loader synld_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .go       (go),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ready    (ready),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .latch    (latch),
    .idle_lvl (idle_lvl),
    .sel_now  (sel_now)
);

// File: tb/test_synth_loader.sv
module test_synth_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ready, ser_clk, ser_data;
    logic [2:0] latch;

    int checks = 0;
    int failures = 0;
    int case_no = 0;

    logic       e_clk [0:511];
    logic       e_dat [0:511];
    logic [2:0] e_lat [0:511];

    always #2 clk = ~clk;

    synth_loader i_synth_loader (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ready(ready),
        .ser_clk(ser_clk), .ser_data(ser_data), .latch(latch)
    );

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // build the expected per-tick waveform, then run and compare
    task automatic run_case(input logic [31:0] d, input logic [2:0] sel,
                            input logic [4:0] lo, input logic [4:0] hi,
                            input logic [4:0] cnt, input bit ord, input bit pol,
                            input bit only_start, input bit inject);
        int n, m, cyc, idx, bad_idx;
        logic lastb;
        n = (cnt == 0) ? 1 : int'(cnt);
        m = 0;
        lastb = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic b;
            b = d[ord ? (n - 1 - k) : k];
            lastb = b;
            for (int t = 0; t <= int'(lo); t++) begin
                e_clk[m] = pol; e_dat[m] = b; e_lat[m] = '0; m++;
            end
            for (int t = 0; t <= int'(hi); t++) begin
                e_clk[m] = !pol; e_dat[m] = b; e_lat[m] = '0; m++;
            end
        end
        if (sel != 0) begin
            for (int t = 0; t <= int'(lo); t++) begin
                e_clk[m] = pol; e_dat[m] = lastb; e_lat[m] = '0; m++;
            end
            for (int t = 0; t <= int'(hi); t++) begin
                e_clk[m] = pol; e_dat[m] = lastb; e_lat[m] = sel; m++;
            end
        end

        if (!only_start) begin
            for (int b = 0; b < 4; b++) wr(3'(b), d[8*b +: 8]);
            wr(3'd4, {sel, lo});
            wr(3'd5, {2'b00, ord, hi});
        end
        wr(3'd6, {2'b00, pol, cnt});
        check(ready == 1'b0, "R3 ready low after start", int'(ready), 0);
        repeat (2) @(negedge clk);

        cyc = 0; idx = 0; bad_idx = -1;
        while (idx <= m) begin
            @(negedge clk);
            tick = 1'b0;
            wr_en = 1'b0;
            if (inject && cyc == 4)  begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = ~d[7:0]; end
            if (inject && cyc == 7)  begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'hFF; end
            if (inject && cyc == 10) begin wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h3F; end
            if (cyc % 3 == 0) begin
                if (idx < m) begin
                    if (bad_idx < 0 && (ser_clk !== e_clk[idx] || ser_data !== e_dat[idx] ||
                                        latch !== e_lat[idx] || ready !== 1'b0)) begin
                        bad_idx = idx;
                        $display("FAIL R4 R5 R6 R7 R8 R9 case %0d tick %0d: got clk=%b dat=%b lat=%b rdy=%b expected clk=%b dat=%b lat=%b rdy=0",
                                 case_no, idx, ser_clk, ser_data, latch, ready,
                                 e_clk[idx], e_dat[idx], e_lat[idx]);
                    end
                end else begin
                    check(ready == 1'b1, "R3 ready back after finish", int'(ready), 1);
                end
                tick = 1'b1;
                idx++;
            end
            cyc++;
        end
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
        checks++;
        if (bad_idx >= 0) failures++;
        case_no++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] sels [0:5];
        logic [4:0] cnts [0:3];
        logic [4:0] los [0:2];
        logic [4:0] his [0:2];
        sels = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd7};
        cnts = '{5'd0, 5'd1, 5'd3, 5'd31};
        los  = '{5'd0, 5'd2, 5'd1};
        his  = '{5'd0, 5'd1, 5'd3};

        repeat (4) @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        check(ser_clk == 1'b0, "R1 ser_clk after reset", int'(ser_clk), 0);
        check(ser_data == 1'b0, "R1 ser_data after reset", int'(ser_data), 0);
        check(latch == 3'd0, "R1 latch after reset", int'(latch), 0);

        // R2 R4 R5 R6 R7 R8 sweep
        for (int p = 0; p < 2; p++)
            for (int o = 0; o < 2; o++)
                for (int s = 0; s < 6; s++)
                    for (int c = 0; c < 4; c++)
                        for (int w = 0; w < 3; w++) begin
                            logic [31:0] dv;
                            dv = 32'hA5C3_1E69 ^ (32'(case_no) * 32'h9E37_79B9);
                            run_case(dv, sels[s], los[w], his[w], cnts[c], o[0], p[0], 1'b0, 1'b0);
                        end

        // R9 writes while busy are ignored, registers keep their values
        run_case(32'h1234_5678, 3'd5, 5'd1, 5'd1, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1);
        run_case(32'h1234_5678, 3'd5, 5'd1, 5'd1, 5'd31, 1'b1, 1'b1, 1'b1, 1'b0);
        run_case(32'h8000_0001, 3'd0, 5'd0, 5'd0, 5'd31, 1'b0, 1'b0, 1'b0, 1'b1);
        run_case(32'h8000_0001, 3'd0, 5'd0, 5'd0, 5'd31, 1'b0, 1'b0, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule